// File: doc/BRIEF.md
# Dual-Port Frame Memory with Streaming Row Buffer

This block is a row-organised frame memory with two independent output paths. The random port works like an ordinary synchronous memory port. It writes single words at a given row and column, and a read returns the addressed word on the following cycle. The random port also accepts a transfer command. That command copies every word of one chosen row into an internal row buffer in a single cycle, and sets the starting column for streaming.

The video port is read-only and has its own data output. It always shows the buffered word at the current stream position. Each shift pulse moves the position one column higher. The buffered copy is isolated from the array, so random reads and writes go on every cycle while the buffer streams, and writes to the buffered row do not disturb the stream. A low-water flag warns when the words left in the buffer fall to a programmable threshold. Stepping past the last column wraps the position to column 0 and raises a sticky underrun flag. The next transfer clears that flag.

Top module: `rowstream_mem`

## Requirements
- R1: A random-port write (rp_en=1, rp_we=1) stores rp_wdata at (rp_row, rp_col). A read (rp_en=1, rp_we=0) presents the stored word on rp_rdata one clock after the request, and a write in an earlier cycle is visible to it.
- R2: rp_rdata changes only in the cycle after a read request. It holds its value after writes and idle cycles.
- R3: After the clock edge that samples xfer_req=1, vid_data shows the word at column xfer_col of row xfer_row, as that row stood before the edge.
- R4: Each shift_pulse without xfer_req moves the stream position to the next higher column, so vid_data shows the following buffered word. With neither input asserted, the position holds.
- R5: Random-port accesses are accepted in the same cycles as shift pulses, and random-port writes, including writes to the buffered row, never change the words that vid_data streams until the next transfer.
- R6: A shift_pulse at the last column moves the position to column 0 and sets underrun. underrun then stays set through further shifts and idle cycles.
- R7: A transfer clears underrun on the same edge that loads the buffer.
- R8: low_water is 1 exactly when (COLS - position) <= lw_thresh, where position is the current stream column. It follows lw_thresh without a clock delay.
- R9: When xfer_req and shift_pulse are both 1 in one cycle, the transfer takes effect and vid_data shows the word at xfer_col of the new row. The shift is dropped.
- R10: Synchronous reset (rst=1) sets rp_rdata to 0, sets the stream position to 0, clears underrun and fills the buffer with zeros, so vid_data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_en | input | 1 | Random-port access request |
| rp_we | input | 1 | 1 = write, 0 = read, when rp_en is 1 |
| rp_row | input | log2(ROWS) | Random-port row address |
| rp_col | input | log2(COLS) | Random-port column address |
| rp_wdata | input | DW | Random-port write data |
| rp_rdata | output | DW | Random-port read data, one cycle after the request |
| xfer_req | input | 1 | Load one whole row into the row buffer |
| xfer_row | input | log2(ROWS) | Row to transfer |
| xfer_col | input | log2(COLS) | Column where streaming starts |
| shift_pulse | input | 1 | Advance the stream by one column |
| lw_thresh | input | log2(COLS)+1 | Low-water threshold in words |
| vid_data | output | DW | Video-port word at the current stream position |
| low_water | output | 1 | Remaining buffered words are at or below lw_thresh |
| underrun | output | 1 | Sticky: the stream wrapped past the last column |

## Verification
Four properties hold on every cycle: a stream step advances the position by exactly one column, the wrap at the last column lands on column 0 with underrun set, underrun stays set until a transfer, and a transfer wins over a coincident shift and clears underrun. They also check that rp_rdata holds without a read and that each write lands at its address. Data integrity across the two ports can only be shown by the bench scenarios. These cover streaming a snapshot of a row while that same row is rewritten, a concurrent read that returns the new word, the low-water boundary at two thresholds, and transfers at non-zero and last start columns.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    // Random-port operation decoded from the enable and write lines
    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_READ  = 2'd1,
        RP_WRITE = 2'd2
    } rp_op_e;

    // Stream-side control for one cycle; a load overrides a step
    typedef enum logic [1:0] {
        SB_HOLD = 2'd0,
        SB_STEP = 2'd1,
        SB_LOAD = 2'd2
    } sb_act_e;

    function automatic rp_op_e rp_decode(input logic en, input logic we);
        if (!en)
            return RP_IDLE;
        return we ? RP_WRITE : RP_READ;
    endfunction

    function automatic sb_act_e sb_decode(input logic load, input logic step);
        if (load)
            return SB_LOAD;
        return step ? SB_STEP : SB_HOLD;
    endfunction

endpackage

// File: rtl/rsm_array.sv
module rsm_array
    import rsm_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned DW   = 8,
    localparam int unsigned RW  = $clog2(ROWS),
    localparam int unsigned CW  = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  rp_op_e                   op,
    input  logic [RW-1:0]            row,
    input  logic [CW-1:0]            col,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic [RW-1:0]            xrow,
    output logic [COLS-1:0][DW-1:0]  xrow_words
);

    logic [COLS-1:0][DW-1:0] mem [ROWS];

    // One write-enable decode per row
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (op == RP_WRITE && row == RW'(r))
                mem[r][col] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (op == RP_READ)
            rdata <= mem[row][col];
    end

    // Whole-row read for the transfer path
    assign xrow_words = mem[xrow];

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op != RP_READ) |=> $stable(rdata)); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (op == RP_WRITE) |=> (mem[$past(row)][$past(col)] == $past(wdata))); // R1

endmodule

// File: rtl/rsm_rowbuf.sv
module rsm_rowbuf
    import rsm_pkg::*;
#(
    parameter int unsigned COLS = 16,
    parameter int unsigned DW   = 8,
    localparam int unsigned CW  = $clog2(COLS),
    localparam logic [CW-1:0] LAST = CW'(COLS - 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sb_act_e                  act,
    input  logic [COLS-1:0][DW-1:0]  load_words,
    input  logic [CW-1:0]            start_col,
    output logic [CW-1:0]            pos,
    output logic [DW-1:0]            word,
    output logic                     underrun
);

    logic [COLS-1:0][DW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            pos      <= '0;
            underrun <= 1'b0;
        end else begin
            unique case (act)
                SB_LOAD: begin
                    held     <= load_words;
                    pos      <= start_col;
                    underrun <= 1'b0;
                end
                SB_STEP: begin
                    if (pos == LAST) begin
                        pos      <= '0;
                        underrun <= 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign word = held[pos];

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (act == SB_STEP && pos != LAST) |=> (pos == $past(pos) + 1'b1)); // R4

    AST_HOLD_POS: assert property (@(posedge clk) disable iff (rst)
        (act == SB_HOLD) |=> ($stable(pos) && $stable(word))); // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (act == SB_STEP && pos == LAST) |=> (pos == '0 && underrun)); // R6

    AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underrun && act != SB_LOAD) |=> underrun); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (act == SB_LOAD) |=> (!underrun && pos == $past(start_col))); // R9

endmodule

// File: rtl/rsm_level.sv
module rsm_level #(
    parameter int unsigned COLS = 16,
    localparam int unsigned CW  = $clog2(COLS)
) (
    input  logic [CW-1:0] pos,
    input  logic [CW:0]   thresh,
    output logic          low
);

    logic [CW:0] left;

    // Words still to stream, counting the one on the output
    assign left = (CW+1)'(COLS) - {1'b0, pos};
    assign low  = (left <= thresh);

endmodule

// File: rtl/rowstream_mem.sv
module rowstream_mem
    import rsm_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned DW   = 8,
    localparam int unsigned RW  = $clog2(ROWS),
    localparam int unsigned CW  = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rp_en,
    input  logic           rp_we,
    input  logic [RW-1:0]  rp_row,
    input  logic [CW-1:0]  rp_col,
    input  logic [DW-1:0]  rp_wdata,
    output logic [DW-1:0]  rp_rdata,
    input  logic           xfer_req,
    input  logic [RW-1:0]  xfer_row,
    input  logic [CW-1:0]  xfer_col,
    input  logic           shift_pulse,
    input  logic [CW:0]    lw_thresh,
    output logic [DW-1:0]  vid_data,
    output logic           low_water,
    output logic           underrun
);

    rp_op_e                  op;
    sb_act_e                 act;
    logic [COLS-1:0][DW-1:0] row_words;
    logic [CW-1:0]           pos;

    assign op  = rp_decode(rp_en, rp_we);
    assign act = sb_decode(xfer_req, shift_pulse);

    rsm_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .row        (rp_row),
        .col        (rp_col),
        .wdata      (rp_wdata),
        .rdata      (rp_rdata),
        .xrow       (xfer_row),
        .xrow_words (row_words)
    );

    rsm_rowbuf #(.COLS(COLS), .DW(DW)) u_rowbuf (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .load_words (row_words),
        .start_col  (xfer_col),
        .pos        (pos),
        .word       (vid_data),
        .underrun   (underrun)
    );

    rsm_level #(.COLS(COLS)) u_level (
        .pos    (pos),
        .thresh (lw_thresh),
        .low    (low_water)
    );

    AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        xfer_req |=> !underrun); // R7

endmodule

// File: tb/test_rowstream_mem.sv
`timescale 1ns/1ps
module test_rowstream_mem;

    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rp_en = 1'b0, rp_we = 1'b0;
    logic [3:0]    rp_row = '0, rp_col = '0;
    logic [7:0]    rp_wdata = '0;
    logic [7:0]    rp_rdata;
    logic          xfer_req = 1'b0;
    logic [3:0]    xfer_row = '0, xfer_col = '0;
    logic          shift_pulse = 1'b0;
    logic [4:0]    lw_thresh = 5'd3;
    logic [7:0]    vid_data;
    logic          low_water, underrun;

    always #2.5 clk = ~clk;

    rowstream_mem #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) i_rowstream_mem (
        .clk(clk), .rst(rst),
        .rp_en(rp_en), .rp_we(rp_we), .rp_row(rp_row), .rp_col(rp_col),
        .rp_wdata(rp_wdata), .rp_rdata(rp_rdata),
        .xfer_req(xfer_req), .xfer_row(xfer_row), .xfer_col(xfer_col),
        .shift_pulse(shift_pulse), .lw_thresh(lw_thresh),
        .vid_data(vid_data), .low_water(low_water), .underrun(underrun)
    );

    int tests = 0;
    int fails = 0;

    // Bench-side model
    logic [7:0] model_mem [ROWS][COLS];
    logic [7:0] snap [COLS];
    int         vpos = 0;
    logic       vunder = 1'b0;
    logic [7:0] last_rd = 8'h00;

    // Scoreboard for random-port reads
    logic [7:0] rd_q [$];
    logic       rd_d = 1'b0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) rd_d <= rp_en && !rp_we && !rst;

    always @(negedge clk) begin
        if (rd_d) begin
            if (rd_q.size() == 0) begin
                check("R1 unexpected read", 1, 0);
            end else begin
                last_rd = rd_q.pop_front();
                check("R1 read data", rp_rdata, last_rd);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int r, input int c, input logic [7:0] d);
        rp_en = 1; rp_we = 1; rp_row = 4'(r); rp_col = 4'(c); rp_wdata = d;
        model_mem[r][c] = d;
        tick();
        rp_en = 0; rp_we = 0;
    endtask

    task automatic rd(input int r, input int c);
        rp_en = 1; rp_we = 0; rp_row = 4'(r); rp_col = 4'(c);
        rd_q.push_back(model_mem[r][c]);
        tick();
        rp_en = 0;
    endtask

    task automatic model_step();
        if (vpos == COLS - 1) begin
            vpos = 0; vunder = 1'b1;
        end else begin
            vpos++;
        end
    endtask

    task automatic xfer(input int r, input int c, input logic with_shift);
        xfer_req = 1; xfer_row = 4'(r); xfer_col = 4'(c); shift_pulse = with_shift;
        for (int k = 0; k < COLS; k++) snap[k] = model_mem[r][k];
        vpos = c; vunder = 1'b0;
        tick();
        xfer_req = 0; shift_pulse = 0;
    endtask

    task automatic shift();
        shift_pulse = 1;
        model_step();
        tick();
        shift_pulse = 0;
    endtask

    task automatic check_vid(input string tag);
        check(tag, vid_data, snap[vpos]);
        check({tag, " underrun"}, underrun, vunder);
    endtask

    task automatic check_low(input string tag);
        check(tag, low_water, ((COLS - vpos) <= int'(lw_thresh)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model_mem[r][c] = 8'h00;
        repeat (3) tick();
        rst = 0;
        tick();

        // R10: reset state
        check("R10 vid_data", vid_data, 8'h00);
        check("R10 underrun", underrun, 1'b0);
        check("R10 rp_rdata", rp_rdata, 8'h00);
        check("R10 low_water", low_water, 1'b0);

        // R1: fill four rows and read a few back
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < COLS; c++)
                wr(r, c, 8'(((r * 16 + c) ^ 8'h5A) & 8'hFF));
        rd(0, 0);
        rd(1, 7);
        rd(3, 15);
        wr(3, 15, 8'hC3);
        rd(3, 15);
        tick();

        // R2: no change without a read
        wr(0, 1, 8'h11);
        tick(); tick();
        check("R2 rdata held", rp_rdata, last_rd);

        // R3 / R4: transfer row 2 from column 0 and stream
        xfer(2, 0, 1'b0);
        check_vid("R3 first word");
        for (int k = 0; k < 3; k++) begin
            shift();
            check_vid("R4 stream step");
        end
        tick();
        check_vid("R4 idle hold");

        // R5: write to the buffered row while shifting, read it concurrently
        rp_en = 1; rp_we = 1; rp_row = 4'd2; rp_col = 4'd5; rp_wdata = 8'hEE;
        model_mem[2][5] = 8'hEE;
        shift_pulse = 1; model_step();
        tick();
        rp_en = 0; rp_we = 0; shift_pulse = 0;
        check_vid("R5 shift with write");
        rp_en = 1; rp_row = 4'd2; rp_col = 4'd5;
        rd_q.push_back(8'hEE);
        shift_pulse = 1; model_step();
        tick();
        rp_en = 0; shift_pulse = 0;
        check_vid("R5 stream at written column");
        check("R5 snapshot kept old word", vid_data, 8'((2 * 16 + 5) ^ 8'h5A));
        wr(2, vpos, 8'h77);
        check_vid("R5 write at current column");

        // R8: low-water boundary
        while (vpos < 12) shift();
        lw_thresh = 5'd3;
        #0.1;
        check_low("R8 at 4 left thr 3");
        check("R8 low clear", low_water, 1'b0);
        lw_thresh = 5'd4;
        #0.1;
        check("R8 threshold follows", low_water, 1'b1);
        lw_thresh = 5'd3;
        shift();
        check_low("R8 at 3 left thr 3");
        check("R8 low set", low_water, 1'b1);

        // R6: wrap and sticky underrun
        while (vpos != COLS - 1) shift();
        check_vid("R6 last column");
        shift();
        check_vid("R6 wrapped to column 0");
        check("R6 underrun set", underrun, 1'b1);
        shift();
        tick();
        check_vid("R6 underrun sticky");

        // R7: transfer clears underrun, non-zero start column
        xfer(3, 10, 1'b0);
        check_vid("R7 after transfer");
        check("R7 underrun cleared", underrun, 1'b0);
        check("R3 start column word", vid_data, 8'((3 * 16 + 10) ^ 8'h5A));

        // R9: transfer and shift together
        xfer(1, 4, 1'b1);
        check_vid("R9 transfer wins");
        shift();
        check_vid("R9 next after transfer");

        // R6: start at the last column then wrap
        xfer(0, 15, 1'b0);
        check_vid("R6 start last");
        shift();
        check_vid("R6 wrap from start last");
        tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule